// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block walks a ring of transmit descriptors that software prepares in a word-wide descriptor store. Software sets a descriptor's ownership flag, then pulses `pollWrite`. The engine reads the status word at its ring pointer. If the engine does not own the descriptor, it stops and raises `suspended`. If it does own it, the engine reads the control and buffer-address words. It then fetches the buffer from a byte-wide buffer store and streams it out on a valid/ready byte interface. Finally it writes a completion status that hands the descriptor back to software, and it moves on to the next descriptor. It keeps going until it meets one it does not own.

A descriptor marked as a setup frame is not sent. Its 192-byte buffer is loaded into a 16-entry destination-address filter. The receive side uses this filter through `matchAddr`/`matchHit` to decide whether a destination address is accepted. Both stores read combinationally. The block drives only their addresses and the status write strobe.

Top module: `txpoll_engine`

## Requirements
- R1: After reset, `txValid`, `descWrEn` and `suspended` are low. Every filter entry holds the all-ones address, so `matchHit` is high for FF:FF:FF:FF:FF:FF and low for any other address.
- R2: A poll accepted while `txEnable` is high reads the status word at the ring pointer. If bit 31 of that word is clear, nothing is written, no byte is sent, and `suspended` is high after the second rising edge counted from the poll edge. It stays high until the next accepted poll.
- R3: For an owned data descriptor, the engine streams the bytes in order, starting at the byte address held in descriptor word 2. It sends exactly the length given in control bits 10:0. `txLast` is raised on the final byte. The engine then writes status 0x00000000, which clears bit 31. A data descriptor needs both bit 29 (first) and bit 30 (last) set in control word 1.
- R4: While `txValid` is high and `txReady` is low, `txData` and `txLast` hold their values.
- R5: With `txReady` held high, an owned data descriptor of L bytes that is followed by a non-owned descriptor brings `suspended` high L+6 rising edges after the poll edge. The status write happens in the cycle after the last byte is accepted.
- R6: A descriptor occupies 4 words: status, control, buffer address, and a spare word. If control bit 25 is clear, the next descriptor is 4 words further on. If it is set, the next descriptor is at `ringBase`.
- R7: A descriptor with control bit 27 set and length 192 sends no bytes. It reloads all filter entries from its buffer and completes with status 0x7FFFFFFF. `suspended` rises 198 edges after the poll when the next descriptor is not owned.
- R8: In the setup buffer, entry k uses bytes 12k to 12k+11. Within each 4-byte group, only the first two bytes are used. The three groups give address bytes 0-1, 2-3 and 4-5. Address byte 0 is `matchAddr[47:40]`.
- R9: `matchHit` is high in the same cycle whenever `matchAddr` equals any filter entry.
- R10: A faulty descriptor sends nothing, leaves the filter unchanged and completes with status 0x00008000 (bit 15, error summary). A descriptor is faulty if its length is 0, if it is a data descriptor without both bits 29 and 30, or if it is a setup descriptor whose length is not 192.
- R11: While `txEnable` is low, polls are ignored: no descriptor is touched and `suspended` keeps its value. The ring pointer returns to `ringBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pollWrite | input | 1 | One-cycle poll demand pulse |
| txEnable | input | 1 | Transmit enable from the operation-mode register |
| ringBase | input | DESC_AW | Word address of descriptor 0 |
| descAddr | output | DESC_AW | Descriptor store word address |
| descRdData | input | 32 | Descriptor store read data, same cycle |
| descWrEn | output | 1 | Status write strobe |
| descWrData | output | 32 | Status word to write |
| bufAddr | output | BUF_AW | Buffer store byte address |
| bufRdData | input | 8 | Buffer store read data, same cycle |
| txData | output | 8 | Transmit byte |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Sink accepts the byte |
| txLast | output | 1 | Final byte of the frame |
| suspended | output | 1 | Engine stopped on a descriptor it does not own |
| matchAddr | input | 48 | Destination address to test |
| matchHit | output | 1 | Address found in the filter |

## Verification
The engine spends three cycles fetching the status, control and buffer words. It then needs one cycle per byte sent or loaded, one cycle for the status write, and two more to fetch and reject the next descriptor. Every poll is therefore timed by counting rising edges from the edge that registers it until `suspended` is seen. The expected count is 2, L+6, 198 or 6 per descriptor, and any earlier or later arrival is an error. Bytes are compared through an ordered queue at the time the handshake completes, whenever the ready pattern lets them through. Status words and filter hits are read at the ports only after `suspended` shows the engine has come to rest.

// File: rtl/txpoll_pkg.sv
package txpoll_pkg;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;
  localparam int FIRST_BIT = 29;
  localparam int SETUP_BIT = 27;
  localparam int WRAP_BIT = 25;
  localparam int ERR_BIT  = 15;

  localparam int DESC_WORDS     = 4;
  localparam int MAC_W          = 48;
  localparam int MAC_BYTES      = MAC_W / 8;
  localparam int ENTRY_BYTES    = 12;

  localparam logic [31:0] ST_DATA_OK  = 32'h0000_0000;
  localparam logic [31:0] ST_SETUP_OK = 32'h7FFF_FFFF;
  localparam logic [31:0] ST_FAULT    = 32'h0000_0001 << ERR_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_CTRL, S_BUF, S_SEND, S_LOAD, S_WBACK
  } stateT;

  typedef enum logic [1:0] { WB_DATA, WB_SETUP, WB_ERR } wbKindT;

  typedef enum logic [1:0] { A_STAT, A_CTRL, A_BUF } addrSelT;

  typedef struct packed {
    logic     latchCtrl;
    logic     latchBuf;
    logic     clrCnt;
    logic     stepCnt;
    logic     loadByte;
    logic     advance;
    logic     rewind;
    addrSelT  addrSel;
    wbKindT   wbKind;
  } strobeT;

endpackage

// File: rtl/txpoll_ctrl.sv
module txpoll_ctrl
  import txpoll_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pollWrite,
  input  logic   txEnable,
  input  logic   ownSeen,
  input  logic   isSetup,
  input  logic   frameBad,
  input  logic   lastByte,
  input  logic   txReady,
  output strobeT strobe,
  output logic   txValid,
  output logic   txLast,
  output logic   descWrEn,
  output logic   suspended
);

  stateT  state, nextState;
  wbKindT wbKindQ, nextKind;
  logic   setSusp, clrSusp;

  always_comb begin
    nextState      = state;
    nextKind       = wbKindQ;
    strobe         = '0;
    strobe.addrSel = A_STAT;
    strobe.wbKind  = wbKindQ;
    txValid        = 1'b0;
    descWrEn       = 1'b0;
    setSusp        = 1'b0;
    clrSusp        = 1'b0;
    case (state)
      S_IDLE: begin
        strobe.rewind = !txEnable;
        if (pollWrite && txEnable) begin
          nextState = S_STAT;
          clrSusp   = 1'b1;
        end
      end
      S_STAT: begin
        if (ownSeen) nextState = S_CTRL;
        else begin
          nextState = S_IDLE;
          setSusp   = 1'b1;
        end
      end
      S_CTRL: begin
        strobe.addrSel   = A_CTRL;
        strobe.latchCtrl = 1'b1;
        nextState        = S_BUF;
      end
      S_BUF: begin
        strobe.addrSel  = A_BUF;
        strobe.latchBuf = 1'b1;
        strobe.clrCnt   = 1'b1;
        if (frameBad) begin
          nextState = S_WBACK;
          nextKind  = WB_ERR;
        end else if (isSetup) begin
          nextState = S_LOAD;
          nextKind  = WB_SETUP;
        end else begin
          nextState = S_SEND;
          nextKind  = WB_DATA;
        end
      end
      S_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          strobe.stepCnt = 1'b1;
          if (lastByte) nextState = S_WBACK;
        end
      end
      S_LOAD: begin
        strobe.stepCnt  = 1'b1;
        strobe.loadByte = 1'b1;
        if (lastByte) nextState = S_WBACK;
      end
      S_WBACK: begin
        descWrEn       = 1'b1;
        strobe.advance = 1'b1;
        nextState      = S_STAT;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign txLast = (state == S_SEND) && lastByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wbKindQ   <= WB_DATA;
      suspended <= 1'b0;
    end else begin
      state   <= nextState;
      wbKindQ <= nextKind;
      if (clrSusp)      suspended <= 1'b0;
      else if (setSusp) suspended <= 1'b1;
    end
  end

endmodule

// File: rtl/txpoll_datapath.sv
module txpoll_datapath
  import txpoll_pkg::*;
#(
  parameter int DESC_AW = 8,
  parameter int BUF_AW  = 12,
  parameter int LEN_W   = 11,
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [DESC_AW-1:0] ringBase,
  input  logic [31:0]        descRdData,
  input  logic [7:0]         bufRdData,
  input  logic [MAC_W-1:0]   matchAddr,
  output logic [DESC_AW-1:0] descAddr,
  output logic [31:0]        descWrData,
  output logic [BUF_AW-1:0]  bufAddr,
  output logic               ownSeen,
  output logic               isSetup,
  output logic               frameBad,
  output logic               lastByte,
  output logic               matchHit
);

  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SETUP_LEN = ENTRIES * ENTRY_BYTES;

  logic [DESC_AW-1:0] ringPtr;
  logic [LEN_W-1:0]   frameLen, byteCnt;
  logic               firstSeg, lastSeg, wrapSeen;
  logic [BUF_AW-1:0]  bufBase;
  logic [IDX_W-1:0]   entryIdx;
  logic [3:0]         entryOff;
  logic [2:0]         slot;
  logic               slotUsed;
  logic [5:0]         slotLsb;
  logic [ENTRIES-1:0] hitVec;
  logic               unusedRdBits;

  assign unusedRdBits = ^descRdData;

  // Ring pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ringPtr <= '0;
    else if (strobe.rewind) ringPtr <= ringBase;
    else if (strobe.advance)
      ringPtr <= wrapSeen ? ringBase : ringPtr + DESC_AW'(DESC_WORDS);
  end

  always_comb begin
    case (strobe.addrSel)
      A_CTRL:  descAddr = ringPtr + DESC_AW'(1);
      A_BUF:   descAddr = ringPtr + DESC_AW'(2);
      default: descAddr = ringPtr;
    endcase
  end

  always_comb begin
    case (strobe.wbKind)
      WB_SETUP: descWrData = ST_SETUP_OK;
      WB_ERR:   descWrData = ST_FAULT;
      default:  descWrData = ST_DATA_OK;
    endcase
  end

  assign ownSeen = descRdData[OWN_BIT];

  // Control and buffer-address words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameLen <= '0;
      firstSeg <= 1'b0;
      lastSeg  <= 1'b0;
      isSetup  <= 1'b0;
      wrapSeen <= 1'b0;
      bufBase  <= '0;
    end else begin
      if (strobe.latchCtrl) begin
        frameLen <= descRdData[LEN_W-1:0];
        firstSeg <= descRdData[FIRST_BIT];
        lastSeg  <= descRdData[LAST_BIT];
        isSetup  <= descRdData[SETUP_BIT];
        wrapSeen <= descRdData[WRAP_BIT];
      end
      if (strobe.latchBuf) bufBase <= descRdData[BUF_AW-1:0];
    end
  end

  always_comb begin
    if (frameLen == '0)  frameBad = 1'b1;
    else if (isSetup)    frameBad = (frameLen != LEN_W'(SETUP_LEN));
    else                 frameBad = !(firstSeg && lastSeg);
  end

  // Byte and setup-slot counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      entryIdx <= '0;
      entryOff <= '0;
    end else if (strobe.clrCnt) begin
      byteCnt  <= '0;
      entryIdx <= '0;
      entryOff <= '0;
    end else if (strobe.stepCnt) begin
      byteCnt <= byteCnt + LEN_W'(1);
      if (strobe.loadByte) begin
        if (entryOff == 4'(ENTRY_BYTES - 1)) begin
          entryOff <= '0;
          entryIdx <= entryIdx + IDX_W'(1);
        end else begin
          entryOff <= entryOff + 4'd1;
        end
      end
    end
  end

  assign bufAddr  = bufBase + BUF_AW'(byteCnt);
  assign lastByte = (byteCnt == LEN_W'(frameLen - LEN_W'(1)));

  // Group in bits 3:2, position in bits 1:0; positions 2 and 3 are skipped.
  assign slotUsed = !entryOff[1];
  assign slot     = {entryOff[3:2], entryOff[0]};
  assign slotLsb  = 6'(MAC_W - 8) - {slot, 3'b000};

  // Address filter
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [MAC_W-1:0] addrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) addrQ <= '1;
      else if (strobe.loadByte && slotUsed && entryIdx == IDX_W'(e))
        addrQ[slotLsb +: 8] <= bufRdData;
    end
    assign hitVec[e] = (addrQ == matchAddr);
  end

  assign matchHit = |hitVec;

endmodule

// File: rtl/txpoll_engine.sv
module txpoll_engine
  import txpoll_pkg::*;
#(
  parameter int DESC_AW = 8,
  parameter int BUF_AW  = 12,
  parameter int LEN_W   = 11,
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pollWrite,
  input  logic               txEnable,
  input  logic [DESC_AW-1:0] ringBase,
  output logic [DESC_AW-1:0] descAddr,
  input  logic [31:0]        descRdData,
  output logic               descWrEn,
  output logic [31:0]        descWrData,
  output logic [BUF_AW-1:0]  bufAddr,
  input  logic [7:0]         bufRdData,
  output logic [7:0]         txData,
  output logic               txValid,
  input  logic               txReady,
  output logic               txLast,
  output logic               suspended,
  input  logic [47:0]        matchAddr,
  output logic               matchHit
);

  strobeT strobe;
  logic   ownSeen, isSetup, frameBad, lastByte;

  txpoll_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pollWrite (pollWrite),
    .txEnable  (txEnable),
    .ownSeen   (ownSeen),
    .isSetup   (isSetup),
    .frameBad  (frameBad),
    .lastByte  (lastByte),
    .txReady   (txReady),
    .strobe    (strobe),
    .txValid   (txValid),
    .txLast    (txLast),
    .descWrEn  (descWrEn),
    .suspended (suspended)
  );

  txpoll_datapath #(
    .DESC_AW (DESC_AW),
    .BUF_AW  (BUF_AW),
    .LEN_W   (LEN_W),
    .ENTRIES (ENTRIES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ringBase   (ringBase),
    .descRdData (descRdData),
    .bufRdData  (bufRdData),
    .matchAddr  (matchAddr),
    .descAddr   (descAddr),
    .descWrData (descWrData),
    .bufAddr    (bufAddr),
    .ownSeen    (ownSeen),
    .isSetup    (isSetup),
    .frameBad   (frameBad),
    .lastByte   (lastByte),
    .matchHit   (matchHit)
  );

  assign txData = bufRdData;

endmodule

// File: rtl/txpoll_checker.sv
module txpoll_checker (
  input logic        clk,
  input logic        rstN,
  input logic        txValid,
  input logic        txReady,
  input logic [7:0]  txData,
  input logic        txLast,
  input logic        descWrEn,
  input logic [31:0] descWrData,
  input logic        suspended
);

  // R4: a stalled byte is held
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  // R3: each completion hands the descriptor back
  a_r3_release_owner: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |-> !descWrData[31]);

  // R2: streaming, status write and the stopped indication never coincide
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txValid, descWrEn, suspended}));

  // R5: the status write follows the accepted final byte
  a_r5_wb_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> descWrEn);

endmodule

bind txpoll_engine txpoll_checker i_chk (.*);

// File: tb/test_txpoll_engine.sv
module test_txpoll_engine;

  localparam int DESC_AW = 8;
  localparam int BUF_AW  = 12;
  localparam int BASE    = 16;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LSEG = 32'h4000_0000;
  localparam logic [31:0] FSEG = 32'h2000_0000;
  localparam logic [31:0] SETB = 32'h0800_0000;
  localparam logic [31:0] WRAP = 32'h0200_0000;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MACA  = 48'h0012_3456_789A;
  localparam logic [47:0] MACB  = 48'hA0B1_C2D3_E4F5;
  localparam logic [47:0] MACC  = 48'h0123_4567_89AB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rstN = 1'b0;
  logic               pollWrite = 1'b0;
  logic               txEnable = 1'b0;
  logic [DESC_AW-1:0] ringBase = DESC_AW'(BASE);
  logic [DESC_AW-1:0] descAddr;
  logic [31:0]        descRdData;
  logic               descWrEn;
  logic [31:0]        descWrData;
  logic [BUF_AW-1:0]  bufAddr;
  logic [7:0]         bufRdData;
  logic [7:0]         txData;
  logic               txValid;
  logic               txReady = 1'b1;
  logic               txLast;
  logic               suspended;
  logic [47:0]        matchAddr = '0;
  logic               matchHit;

  logic [31:0] descMem [256];
  logic [7:0]  bufMem  [4096];

  assign descRdData = descMem[descAddr];
  assign bufRdData  = bufMem[bufAddr];
  always @(posedge clk) if (descWrEn) descMem[descAddr] <= descWrData;

  txpoll_engine i_txpoll_engine (.*);

  int checks = 0;
  int errors = 0;
  logic [8:0] expQ[$];
  bit stallMode = 1'b0;
  int stallCnt = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    stallCnt++;
    txReady <= stallMode ? (stallCnt % 3 != 0) : 1'b1;
  end

  // Monitor: scoreboard pop on every handshake; R4 hold check
  logic       wasStall = 1'b0;
  logic [8:0] stallVal = '0;
  always begin
    @(negedge clk);
    #5;
    if (rstN) begin
      if (wasStall)
        check(txValid && {txLast, txData} == stallVal, "R4 hold while stalled",
              {txValid, txLast, txData}, {1'b1, stallVal});
      wasStall = txValid && !txReady;
      stallVal = {txLast, txData};
      if (txValid && txReady) begin
        if (expQ.size() == 0) check(1'b0, "R3 unexpected byte", {txLast, txData}, 0);
        else begin
          logic [8:0] e;
          e = expQ.pop_front();
          check({txLast, txData} == e, "R3 byte/last", {txLast, txData}, e);
        end
      end
    end
  end

  function automatic int dw(input int idx, input int word);
    return BASE + 4 * idx + word;
  endfunction

  task automatic putDesc(input int idx, input logic [31:0] st, input logic [31:0] ctl, input int buf0);
    descMem[dw(idx, 0)] = st;
    descMem[dw(idx, 1)] = ctl;
    descMem[dw(idx, 2)] = 32'(buf0);
    descMem[dw(idx, 3)] = 32'h0;
  endtask

  task automatic loadFrame(input int buf0, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + 7 * i);
      bufMem[buf0 + i] = b;
      expQ.push_back({i == len - 1, b});
    end
  endtask

  task automatic poll();
    @(negedge clk) pollWrite = 1'b1;
    @(negedge clk) pollWrite = 1'b0;
  endtask

  // Counts rising edges from the poll edge until suspended is seen.
  task automatic waitSusp(input int expN, input string tag);
    int n = 1;
    while (!suspended && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (expN > 0) check(suspended && n == expN, tag, n, expN);
    else check(suspended, tag, suspended, 1);
  endtask

  task automatic hit(input logic [47:0] a, input bit exp, input string tag);
    @(negedge clk) matchAddr = a;
    #1 check(matchHit == exp, tag, matchHit, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) descMem[i] = 32'h0;
    for (int i = 0; i < 4096; i++) bufMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!txValid && !descWrEn && !suspended, "R1 outputs idle", {txValid, descWrEn, suspended}, 0);
    hit(BCAST, 1'b1, "R1 broadcast accepted");
    hit(MACC, 1'b0, "R1 other address rejected");
    repeat (2) @(negedge clk);
    txEnable = 1'b1;

    // R2 unowned descriptor
    putDesc(0, 32'h0000_1234, FSEG | LSEG | 4, 'h100);
    poll();
    waitSusp(2, "R2 suspend latency");
    check(descMem[dw(0, 0)] == 32'h0000_1234, "R2 status untouched", descMem[dw(0, 0)], 32'h1234);

    // R3/R5 data frame, ready always high
    putDesc(0, OWN, FSEG | LSEG | 5, 'h100);
    loadFrame('h100, 5, 8'h31);
    poll();
    waitSusp(11, "R5 latency L=5");
    check(descMem[dw(0, 0)] == 32'h0, "R3 data status", descMem[dw(0, 0)], 0);
    check(expQ.size() == 0, "R3 all bytes sent", expQ.size(), 0);

    // R4/R6 stalled frame at next descriptor (+4 words)
    stallMode = 1'b1;
    putDesc(1, OWN, FSEG | LSEG | 9, 'h200);
    loadFrame('h200, 9, 8'hC4);
    poll();
    waitSusp(-1, "R4 stalled frame completes");
    stallMode = 1'b0;
    check(descMem[dw(1, 0)] == 32'h0, "R6 next descriptor used", descMem[dw(1, 0)], 0);
    check(expQ.size() == 0, "R4 all bytes sent", expQ.size(), 0);

    // R10 faults, R6 wrap on control bit 25
    putDesc(2, OWN, FSEG | LSEG | 0, 'h300);
    putDesc(3, OWN, WRAP | LSEG | 6, 'h300);
    descMem[dw(4, 0)] = OWN;
    poll();
    waitSusp(10, "R10 two faulty descriptors latency");
    check(descMem[dw(2, 0)] == 32'h0000_8000, "R10 zero length", descMem[dw(2, 0)], 32'h8000);
    check(descMem[dw(3, 0)] == 32'h0000_8000, "R10 missing first", descMem[dw(3, 0)], 32'h8000);
    check(descMem[dw(4, 0)] == OWN, "R6 wrap skips beyond ring", descMem[dw(4, 0)], OWN);

    // R7/R8 setup frame at ringBase after the wrap
    for (int i = 0; i < 192; i++) bufMem['h400 + i] = (i % 4 < 2) ? 8'hFF : 8'h5A;
    for (int k = 0; k < 2; k++) begin
      logic [47:0] m;
      m = (k == 0) ? MACA : MACB;
      for (int b = 0; b < 6; b++)
        bufMem['h400 + 12 * k + 4 * (b / 2) + (b % 2)] = m[47 - 8 * b -: 8];
    end
    putDesc(0, OWN, SETB | 192, 'h400);
    poll();
    waitSusp(198, "R7 setup latency");
    check(descMem[dw(0, 0)] == 32'h7FFF_FFFF, "R7 setup status", descMem[dw(0, 0)], 32'h7FFF_FFFF);
    check(expQ.size() == 0, "R7 nothing sent", expQ.size(), 0);
    hit(MACA, 1'b1, "R8 entry 0 layout");
    hit(MACB, 1'b1, "R8 entry 1 layout");
    hit(BCAST, 1'b1, "R9 filled entries accept broadcast");
    hit(MACC, 1'b0, "R9 absent address rejected");

    // R10 bad setup length: filter unchanged
    for (int i = 0; i < 192; i++) bufMem['h500 + i] = 8'h00;
    putDesc(1, OWN, SETB | 100, 'h500);
    poll();
    waitSusp(6, "R10 bad setup latency");
    check(descMem[dw(1, 0)] == 32'h0000_8000, "R10 bad setup status", descMem[dw(1, 0)], 32'h8000);
    hit(MACA, 1'b1, "R10 filter kept");

    // R11 disabled polls ignored, pointer rewinds
    putDesc(2, OWN, FSEG | LSEG | 4, 'h600);
    @(negedge clk) txEnable = 1'b0;
    poll();
    repeat (6) @(negedge clk);
    check(descMem[dw(2, 0)] == OWN, "R11 descriptor untouched", descMem[dw(2, 0)], OWN);
    check(suspended, "R11 suspended kept", suspended, 1);
    putDesc(0, OWN, FSEG | LSEG | 3, 'h700);
    loadFrame('h700, 3, 8'h0F);
    @(negedge clk) txEnable = 1'b1;
    poll();
    waitSusp(9, "R11 restart at ringBase latency");
    check(descMem[dw(0, 0)] == 32'h0, "R11 ringBase descriptor sent", descMem[dw(0, 0)], 0);
    check(descMem[dw(2, 0)] == OWN, "R11 old pointer not used", descMem[dw(2, 0)], OWN);
    check(expQ.size() == 0, "R3 restart bytes sent", expQ.size(), 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule